// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Takeover

This block controls eight bidirectional pads from a small register bus. Software writes a data register and a direction register. It reads back an input register that holds the synchronized state of the pads. Each pad gets an output value and an output-enable from the block, and its sampled level comes back in through a two-flop synchronizer.

Two peripheral functions can take over pads without touching the stored registers. A CAN controller owns a transmit pad and a receive pad whenever it is enabled. An SPI owns a slave-select pad and a MISO pad whenever it is enabled and not in bidirectional mode. A fixed priority decides which function a pad serves: CAN first, then SPI, then general-purpose I/O. By default the SPI pads sit on the same two pads as the CAN pads, so that the priority order has effect.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data, direction and input registers all read zero, and every pad output-enable is low.
- R2: Bus offset 0 selects the data register, offset 1 the input register and offset 2 the direction register. A read of offset 3 returns zero.
- R3: A pad under general-purpose control has its output-enable equal to its direction bit (1 = output). Its output value is its data register bit. The direction register reads back what was written.
- R4: A read of offset 0 returns, for each bit, the stored data bit where the direction bit is 1 and the synchronized pad level where it is 0.
- R5: A read of offset 1 returns the synchronized pad level for every pad, whatever its direction. A write to offset 1 changes neither the data register nor the direction register.
- R6: Pad levels reach the input register through two clocked stages. The input register still reads zero after the first rising edge following reset release. It shows the pad levels after the second.
- R7: While the CAN function is enabled, pad 3 (transmit) is enabled as an output carrying the CAN transmit value, and pad 2 (receive) has its output-enable low. The stored direction bits stay unchanged.
- R8: A pad claimed by more than one function follows CAN over SPI and SPI over general-purpose I/O.
- R9: While the SPI is enabled and not bidirectional, pad 3 (slave select) and pad 2 (MISO) take their output value and output-enable from the SPI. In bidirectional mode the SPI claims no pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output-enables |
| can_en | input | 1 | CAN function enabled |
| can_tx | input | 1 | CAN transmit value |
| spi_en | input | 1 | SPI function enabled |
| spi_bidir | input | 1 | SPI in bidirectional mode |
| spi_ss_o | input | 1 | SPI slave-select output value |
| spi_ss_oe | input | 1 | SPI slave-select output-enable |
| spi_miso_o | input | 1 | SPI MISO output value |
| spi_miso_oe | input | 1 | SPI MISO output-enable |

## Verification
The latency assertion assumes that pad levels are sampled only at rising clock edges and that reset has been released for at least two edges. The bench changes pads half a cycle away from the edge and waits three cycles before it reads. The takeover assertions assume the peripheral enables are steady across an edge. The bench changes them only between edges, and never in the same cycle as a direction write, so the check that the stored direction holds is not muddled by a legitimate write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int OFF_DATA  = 0;
  localparam int OFF_INPUT = 1;
  localparam int OFF_DIR   = 2;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_SPI  = 2'd1,
    OWN_CAN  = 2'd2
  } pad_owner_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg1_q, stg2_q;
  logic [W-1:0] stg1_d, stg2_d;
  logic [1:0]   age_q, age_d;

  always_comb begin
    stg1_d = async_i;
    stg2_d = stg1_q;
    age_d  = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
      age_q  <= '0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
      age_q  <= age_d;
    end
  end

  assign sync_o = stg2_q;

  // R6: two-edge latency from pad to synchronized value
  assert_sync_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (sync_o == $past(async_i, 2)));

  // R1 / R6: nothing leaks through in the first edge after reset
  assert_sync_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (sync_o == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  rdata
);
  localparam logic [AW-1:0] A_DATA  = AW'(OFF_DATA);
  localparam logic [AW-1:0] A_INPUT = AW'(OFF_INPUT);
  localparam logic [AW-1:0] A_DIR   = AW'(OFF_DIR);

  logic [W-1:0] data_d, dir_d;
  logic         data_en, dir_en;

  always_comb begin
    data_en = we && (addr == A_DATA);
    dir_en  = we && (addr == A_DIR);
    data_d  = data_en ? wdata : data_q;
    dir_d   = dir_en  ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_DATA:  rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
      A_INPUT: rdata = pin_sync;
      A_DIR:   rdata = dir_q;
      default: rdata = '0;
    endcase
  end

  // R5: a write to the input offset leaves the stored registers alone
  assert_input_wr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_INPUT) |=> ($stable(data_q) && $stable(dir_q)));

  // R2: offsets above the direction register read zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > A_DIR) |-> (rdata == '0));

  // R3: direction register holds its value when it is not addressed
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int W        = PORT_W,
  parameter int CAN_TX_P = 3,
  parameter int CAN_RX_P = 2,
  parameter int SPI_SS_P = 3,
  parameter int SPI_MI_P = 2
) (
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic         can_en,
  input  logic         can_tx,
  input  logic         spi_en,
  input  logic         spi_bidir,
  input  logic         spi_ss_o,
  input  logic         spi_ss_oe,
  input  logic         spi_miso_o,
  input  logic         spi_miso_oe,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  logic spi_claims;
  assign spi_claims = spi_en && !spi_bidir;

  for (genvar i = 0; i < W; i++) begin : g_pad
    pad_owner_e owner;
    logic       per_o, per_oe;

    always_comb begin
      owner  = OWN_GPIO;
      per_o  = 1'b0;
      per_oe = 1'b0;
      if (can_en && (i == CAN_TX_P)) begin
        owner  = OWN_CAN;
        per_o  = can_tx;
        per_oe = 1'b1;
      end else if (can_en && (i == CAN_RX_P)) begin
        owner  = OWN_CAN;
        per_o  = 1'b0;
        per_oe = 1'b0;
      end else if (spi_claims && (i == SPI_SS_P)) begin
        owner  = OWN_SPI;
        per_o  = spi_ss_o;
        per_oe = spi_ss_oe;
      end else if (spi_claims && (i == SPI_MI_P)) begin
        owner  = OWN_SPI;
        per_o  = spi_miso_o;
        per_oe = spi_miso_oe;
      end
    end

    always_comb begin
      if (owner == OWN_GPIO) begin
        pad_o[i]  = data_q[i];
        pad_oe[i] = dir_q[i];
      end else begin
        pad_o[i]  = per_o;
        pad_oe[i] = per_oe;
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W        = PORT_W,
  parameter int AW       = ADDR_W,
  parameter int CAN_TX_P = 3,
  parameter int CAN_RX_P = 2,
  parameter int SPI_SS_P = 3,
  parameter int SPI_MI_P = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  pad_o,
  output logic [W-1:0]  pad_oe,
  input  logic          can_en,
  input  logic          can_tx,
  input  logic          spi_en,
  input  logic          spi_bidir,
  input  logic          spi_ss_o,
  input  logic          spi_ss_oe,
  input  logic          spi_miso_o,
  input  logic          spi_miso_oe
);
  logic [W-1:0] pin_sync, data_q, dir_q;

  gpio_sync2 #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pad_i), .sync_o(pin_sync)
  );

  gpio_regfile #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_sync),
    .data_q(data_q), .dir_q(dir_q), .rdata(bus_rdata)
  );

  gpio_pad_mux #(
    .W(W), .CAN_TX_P(CAN_TX_P), .CAN_RX_P(CAN_RX_P),
    .SPI_SS_P(SPI_SS_P), .SPI_MI_P(SPI_MI_P)
  ) u_mux (
    .data_q(data_q), .dir_q(dir_q),
    .can_en(can_en), .can_tx(can_tx),
    .spi_en(spi_en), .spi_bidir(spi_bidir),
    .spi_ss_o(spi_ss_o), .spi_ss_oe(spi_ss_oe),
    .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe),
    .pad_o(pad_o), .pad_oe(pad_oe)
  );

  localparam logic [AW-1:0] A_DIR = AW'(OFF_DIR);

  // R7: CAN forces transmit pad out, receive pad in
  assert_can_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    can_en |-> (pad_oe[CAN_TX_P] && !pad_oe[CAN_RX_P] && pad_o[CAN_TX_P] == can_tx));

  // R7: CAN takeover never disturbs stored direction
  assert_can_keeps_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (can_en && !(bus_we && bus_addr == A_DIR)) |=> $stable(dir_q));

  // R8 / R9: SPI drives its pads when CAN is absent and SPI is not bidirectional
  assert_spi_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!can_en && spi_en && !spi_bidir) |->
      (pad_oe[SPI_SS_P] == spi_ss_oe && pad_oe[SPI_MI_P] == spi_miso_oe));

  // R3: with no peripheral claim, enables follow the direction register
  assert_gpio_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!can_en && !(spi_en && !spi_bidir)) |-> (pad_oe == dir_q));
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pad_i, pad_o, pad_oe;
  logic can_en, can_tx, spi_en, spi_bidir;
  logic spi_ss_o, spi_ss_oe, spi_miso_o, spi_miso_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .can_en(can_en), .can_tx(can_tx),
    .spi_en(spi_en), .spi_bidir(spi_bidir), .spi_ss_o(spi_ss_o),
    .spi_ss_oe(spi_ss_oe), .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe)
  );

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] dat;
    logic [7:0] pin;
    logic       can;
    logic       spi;
    logic       bid;
    logic [7:0] exp_oe;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'h0F, 8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 8'h0F},
    '{8'hF0, 8'h5A, 8'hC3, 1'b1, 1'b0, 1'b0, 8'hF8},
    '{8'h00, 8'hFF, 8'h81, 1'b0, 1'b1, 1'b0, 8'h0C},
    '{8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00},
    '{8'hFF, 8'h33, 8'h00, 1'b1, 1'b1, 1'b0, 8'hFB},
    '{8'h04, 8'h04, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h08}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_out(input vec_t v);
    logic [7:0] o;
    o = v.dat;
    if (v.can) o[3] = 1'b1;
    else if (v.spi && !v.bid) begin o[3] = 1'b0; o[2] = 1'b1; end
    return o;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    pad_i = 8'hFF; can_en = 1'b0; can_tx = 1'b1; spi_en = 1'b0; spi_bidir = 1'b0;
    spi_ss_o = 1'b0; spi_ss_oe = 1'b1; spi_miso_o = 1'b1; spi_miso_oe = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, r); chk("R1 data", r, 8'h00);
    rd(2'd2, r); chk("R1 dir", r, 8'h00);
    rd(2'd1, r); chk("R1 input", r, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    // R6: one edge after release still zero, two edges shows pads
    @(negedge clk); rd(2'd1, r); chk("R6 first edge", r, 8'h00);
    @(negedge clk); rd(2'd1, r); chk("R6 second edge", r, 8'hFF);

    // vector table walk
    for (int k = 0; k < NV; k++) begin
      wr(2'd2, VEC[k].dir);
      wr(2'd0, VEC[k].dat);
      pad_i = VEC[k].pin; can_en = VEC[k].can;
      spi_en = VEC[k].spi; spi_bidir = VEC[k].bid;
      repeat (3) @(negedge clk);
      chk("R3/R7/R8/R9 oe", pad_oe, VEC[k].exp_oe);
      chk("R3/R7/R9 out", pad_o & pad_oe, exp_out(VEC[k]) & VEC[k].exp_oe);
      rd(2'd0, r); chk("R4 data read", r, (VEC[k].dat & VEC[k].dir) | (VEC[k].pin & ~VEC[k].dir));
      rd(2'd1, r); chk("R5 input read", r, VEC[k].pin);
      rd(2'd2, r); chk("R7 dir kept", r, VEC[k].dir);
      can_en = 1'b0; spi_en = 1'b0; spi_bidir = 1'b0;
    end

    // R9: SPI output-enable low releases MISO pad even with direction out
    wr(2'd2, 8'hFF);
    spi_en = 1'b1; spi_miso_oe = 1'b0;
    @(negedge clk);
    chk("R9 miso oe off", pad_oe, 8'hFB);
    spi_en = 1'b0; spi_miso_oe = 1'b1;

    // R5: write to input offset ignored
    wr(2'd0, 8'h96);
    pad_i = 8'h5A;
    wr(2'd1, 8'h00);
    repeat (2) @(negedge clk);
    rd(2'd1, r); chk("R5 input after write", r, 8'h5A);
    rd(2'd0, r); chk("R5 data untouched", r, 8'h96);
    rd(2'd2, r); chk("R5 dir untouched", r, 8'hFF);

    // R2: unmapped offset reads zero
    rd(2'd3, r); chk("R2 offset 3", r, 8'h00);

    // R3: all-input direction drops every enable
    wr(2'd2, 8'h00);
    chk("R3 all input", pad_oe, 8'h00);
    rd(2'd0, r); chk("R4 all input data read", r, 8'h5A);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule